// File: doc/BRIEF.md
# Serial Controller Host Register File

This block is the software-visible register front end of a byte-oriented serial controller. A host reaches eight byte registers through a synchronous read/write strobe bus. It can set the line format and the 16-bit clock divisor, enable interrupt sources, drive the modem control lines and keep a scratch byte. It can also read the line and modem status and ask which interrupt source is active. The character side is parallel. A transmitted byte leaves as a one-cycle strobe. A received byte is offered with a valid and taken under a ready handshake. A break event comes in on its own pin.

The interrupt line is the registered "any source pending" view of the identification value. A received byte ranks above an empty transmitter. The empty-transmitter source uses a hidden pending flag. That flag is raised by a data write or an enable write, and it is dropped when the host reads the identification register and sees that source. In local loopback, written bytes go back into the receive buffer instead of onto the line, and the modem status read shows the modem control bits.

Top module: `serial_hostregs`

## Requirements
- R1: Only `addr[2:0]` selects a register. Offset 3 (line control) and offset 7 (scratch) read back the full written byte. `brk_o` follows line-control bit 6 and `mctl_o` follows modem-control bits 3:0.
- R2: While line-control bit 7 is 1, offsets 0 and 1 read and write the low and high divisor bytes, and `divisor_o` shows the divisor. In this mode a write to offset 0 sends nothing, and a read of offset 0 leaves line status unchanged.
- R3: Offset 1 keeps only bits 3:0 of a write. Offset 4 keeps only bits 4:0. Writes to offsets 2, 5 and 6 change nothing.
- R4: Offset 2 reads 0x04 if line-status bit 0 and enable bit 0 are both set. Otherwise it reads 0x02 if the pending flag and enable bit 1 are both set. Otherwise it reads 0x01. `irq_o` is 1 exactly when that value is not 0x01, and it lags the register state by one clock.
- R5: A data write (offset 0, bit 7 of line control clear, no loopback) pulses `tx_valid_o` for one cycle with the byte on `tx_byte_o`. It also sets line-status bits 5 and 6 and the pending flag.
- R6: A write to offset 1 sets the pending flag when line-status bit 5 is 1. A read of offset 2 that returns 0x02 clears the pending flag.
- R7: A byte on `rx_byte` is taken only while line-status bit 0 is clear (`rx_ready_o` is 1). Taking it stores the byte and sets bit 0. Reading offset 0 clears line-status bits 0 and 4.
- R8: A `brk_in` pulse loads 0x00 into the receive buffer and sets line-status bits 4 and 0.
- R9: With modem-control bit 4 set, a data write gives no `tx_valid_o` pulse. The byte is placed in the receive buffer and line-status bit 0 is set.
- R10: Offset 6 reads `{modem_in, 4'b0}` with `modem_in` ordered {carrier, ring, set-ready, clear-to-send}. In loopback it reads modem-control bits {3, 2, 0, 1} on bits 7:4, with zeros below.
- R11: After reset, offset 2 reads 0x01, offset 5 reads 0x60 and offset 6 reads 0xB0. All other registers, the divisor and all outputs are 0, except `rx_ready_o`, which is 1.
- R12: `rdata` is loaded on the clock edge that samples `rd_en` and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| irq_o | output | 1 | Interrupt request, level |
| tx_valid_o | output | 1 | Transmit byte strobe |
| tx_byte_o | output | 8 | Transmitted byte |
| rx_valid | input | 1 | Receive byte offered |
| rx_byte | input | 8 | Received byte |
| rx_ready_o | output | 1 | Receive buffer can accept |
| brk_in | input | 1 | Break received event |
| modem_in | input | 4 | Modem status lines {carrier, ring, set-ready, clear-to-send} |
| mctl_o | output | 4 | Modem control lines |
| brk_o | output | 1 | Send break |
| divisor_o | output | 16 | Clock divisor |

## Verification
Read data, status bits and the transmit strobe are all due on the first clock edge after the strobe. The bench drives every access on a falling edge and samples the result on the next falling edge. `irq_o` reflects the state one edge later, so each interrupt check waits one extra idle cycle. `modem_in` is also registered before it is read, so the bench waits one idle cycle after changing it before reading offset 6.

// File: rtl/serial_hostregs_pkg.sv
package serial_hostregs_pkg;
  localparam int BYTE_W = 8;
  localparam int SEL_W  = 3;

  typedef enum logic [SEL_W-1:0] {
    OFS_DATA    = 3'd0,
    OFS_IEN     = 3'd1,
    OFS_IID     = 3'd2,
    OFS_LCTL    = 3'd3,
    OFS_MCTL    = 3'd4,
    OFS_LSTAT   = 3'd5,
    OFS_MSTAT   = 3'd6,
    OFS_SCRATCH = 3'd7
  } reg_ofs_e;

  localparam logic [BYTE_W-1:0] IID_NONE  = 8'h01;
  localparam logic [BYTE_W-1:0] IID_TXE   = 8'h02;
  localparam logic [BYTE_W-1:0] IID_RXD   = 8'h04;
  localparam logic [BYTE_W-1:0] LSTAT_RST = 8'h60;
  localparam logic [BYTE_W-1:0] MSTAT_RST = 8'hB0;

  localparam int LS_DR   = 0;
  localparam int LS_BI   = 4;
  localparam int LS_THRE = 5;
  localparam int LS_TEMT = 6;
  localparam int LC_BRK  = 6;
  localparam int LC_DLAB = 7;
  localparam int MC_LOOP = 4;
  localparam int IEN_W   = 4;
  localparam int MCTL_W  = 5;
endpackage

// File: rtl/sh_irq_id.sv
module sh_irq_id
  import serial_hostregs_pkg::*;
(
  input  logic              data_ready,
  input  logic              rx_en,
  input  logic              tx_pend,
  input  logic              tx_en,
  output logic [BYTE_W-1:0] id
);
  always_comb begin
    if (data_ready && rx_en)  id = IID_RXD;
    else if (tx_pend && tx_en) id = IID_TXE;
    else                       id = IID_NONE;
  end
endmodule

// File: rtl/sh_modem_view.sv
module sh_modem_view
  import serial_hostregs_pkg::*;
#(
  parameter int LINES = 4
) (
  input  logic              loop_en,
  input  logic [LINES-1:0]  mctl,
  input  logic [BYTE_W-1:0] ext_stat,
  output logic [BYTE_W-1:0] view
);
  // loopback wiring: out2->bit7, out1->bit6, dtr->bit5, rts->bit4
  logic [LINES-1:0] looped;
  assign looped = {mctl[3], mctl[2], mctl[0], mctl[1]};

  always_comb begin
    if (loop_en) view = {looped, {(BYTE_W-LINES){1'b0}}};
    else         view = ext_stat;
  end
endmodule

// File: rtl/serial_hostregs.sv
module serial_hostregs
  import serial_hostregs_pkg::*;
#(
  parameter int ADDR_W  = 3,
  parameter int MODEM_W = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [BYTE_W-1:0]    wdata,
  output logic [BYTE_W-1:0]    rdata,
  output logic                 irq_o,
  output logic                 tx_valid_o,
  output logic [BYTE_W-1:0]    tx_byte_o,
  input  logic                 rx_valid,
  input  logic [BYTE_W-1:0]    rx_byte,
  output logic                 rx_ready_o,
  input  logic                 brk_in,
  input  logic [MODEM_W-1:0]   modem_in,
  output logic [MODEM_W-1:0]   mctl_o,
  output logic                 brk_o,
  output logic [2*BYTE_W-1:0]  divisor_o
);
  localparam int DIV_W = 2 * BYTE_W;

  logic [DIV_W-1:0]  div_q;
  logic [BYTE_W-1:0] rbr_q, lcr_q, lsr_q, msr_q, scr_q;
  logic [IEN_W-1:0]  ier_q;
  logic [MCTL_W-1:0] mcr_q;
  logic              pend_q;
  logic [BYTE_W-1:0] rdata_q, tx_byte_q;
  logic              irq_q, tx_valid_q;

  reg_ofs_e          sel;
  logic              dlab, loop_en;
  logic [BYTE_W-1:0] iid_w, mview_w, rd_mux;

  assign sel     = reg_ofs_e'(addr[SEL_W-1:0]);
  assign dlab    = lcr_q[LC_DLAB];
  assign loop_en = mcr_q[MC_LOOP];

  sh_irq_id u_irq_id (
    .data_ready (lsr_q[LS_DR]),
    .rx_en      (ier_q[0]),
    .tx_pend    (pend_q),
    .tx_en      (ier_q[1]),
    .id         (iid_w)
  );

  sh_modem_view #(.LINES(MODEM_W)) u_modem_view (
    .loop_en  (loop_en),
    .mctl     (mcr_q[MODEM_W-1:0]),
    .ext_stat (msr_q),
    .view     (mview_w)
  );

  always_comb begin
    case (sel)
      OFS_DATA:    rd_mux = dlab ? div_q[BYTE_W-1:0] : rbr_q;
      OFS_IEN:     rd_mux = dlab ? div_q[DIV_W-1:BYTE_W]
                                 : {{(BYTE_W-IEN_W){1'b0}}, ier_q};
      OFS_IID:     rd_mux = iid_w;
      OFS_LCTL:    rd_mux = lcr_q;
      OFS_MCTL:    rd_mux = {{(BYTE_W-MCTL_W){1'b0}}, mcr_q};
      OFS_LSTAT:   rd_mux = lsr_q;
      OFS_MSTAT:   rd_mux = mview_w;
      default:     rd_mux = scr_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q      <= '0;
      rbr_q      <= '0;
      ier_q      <= '0;
      lcr_q      <= '0;
      mcr_q      <= '0;
      lsr_q      <= LSTAT_RST;
      msr_q      <= MSTAT_RST;
      scr_q      <= '0;
      pend_q     <= 1'b0;
      rdata_q    <= '0;
      irq_q      <= 1'b0;
      tx_valid_q <= 1'b0;
      tx_byte_q  <= '0;
    end else begin
      tx_valid_q <= 1'b0;
      msr_q      <= {modem_in, {(BYTE_W-MODEM_W){1'b0}}};
      irq_q      <= (iid_w != IID_NONE);

      // read side effects (lowest precedence on shared bits)
      if (rd_en) begin
        rdata_q <= rd_mux;
        if (sel == OFS_DATA && !dlab) begin
          lsr_q[LS_DR] <= 1'b0;
          lsr_q[LS_BI] <= 1'b0;
        end
        if (sel == OFS_IID && iid_w == IID_TXE) pend_q <= 1'b0;
      end

      // external receive path
      if (rx_valid && !lsr_q[LS_DR]) begin
        rbr_q        <= rx_byte;
        lsr_q[LS_DR] <= 1'b1;
      end
      if (brk_in) begin
        rbr_q        <= '0;
        lsr_q[LS_DR] <= 1'b1;
        lsr_q[LS_BI] <= 1'b1;
      end

      // host writes (highest precedence)
      if (wr_en) begin
        case (sel)
          OFS_DATA: begin
            if (dlab) begin
              div_q[BYTE_W-1:0] <= wdata;
            end else begin
              pend_q         <= 1'b1;
              lsr_q[LS_THRE] <= 1'b1;
              lsr_q[LS_TEMT] <= 1'b1;
              if (loop_en) begin
                rbr_q        <= wdata;
                lsr_q[LS_DR] <= 1'b1;
              end else begin
                tx_valid_q <= 1'b1;
                tx_byte_q  <= wdata;
              end
            end
          end
          OFS_IEN: begin
            if (dlab) begin
              div_q[DIV_W-1:BYTE_W] <= wdata;
            end else begin
              ier_q <= wdata[IEN_W-1:0];
              if (lsr_q[LS_THRE]) pend_q <= 1'b1;
            end
          end
          OFS_LCTL:    lcr_q <= wdata;
          OFS_MCTL:    mcr_q <= wdata[MCTL_W-1:0];
          OFS_SCRATCH: scr_q <= wdata;
          default: ;
        endcase
      end
    end
  end

  assign rdata      = rdata_q;
  assign irq_o      = irq_q;
  assign tx_valid_o = tx_valid_q;
  assign tx_byte_o  = tx_byte_q;
  assign rx_ready_o = ~lsr_q[LS_DR];
  assign mctl_o     = mcr_q[MODEM_W-1:0];
  assign brk_o      = lcr_q[LC_BRK];
  assign divisor_o  = div_q;
endmodule

// File: rtl/sh_checker.sv
module sh_checker (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic       rd_en,
  input logic [2:0] sel,
  input logic [7:0] rdata,
  input logic       rx_valid,
  input logic [7:0] rx_byte,
  input logic       brk_in,
  input logic       tx_valid,
  input logic       irq,
  input logic [7:0] lsr,
  input logic [7:0] rbr,
  input logic       pend,
  input logic [4:0] mcr,
  input logic [7:0] lcr,
  input logic [7:0] iid
);
  logic data_wr, loop_wr;
  assign data_wr = wr_en && sel == 3'd0 && !lcr[7];
  assign loop_wr = data_wr && mcr[4];

  p_irq_follows_id_r4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == $past(iid != 8'h01)));

  p_ien_nibble_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_en && sel == 3'd1 && !lcr[7]) |=> (rdata[7:4] == 4'h0));

  p_rx_accept_r7: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !lsr[0] && !brk_in && !loop_wr) |=>
      (lsr[0] && rbr == $past(rx_byte)));

  p_break_load_r8: assert property (@(posedge clk) disable iff (rst)
    (brk_in && !loop_wr) |=> (rbr == 8'h00 && lsr[4] && lsr[0]));

  p_tx_route_r9: assert property (@(posedge clk) disable iff (rst)
    data_wr |=> (tx_valid == !$past(mcr[4])));

  p_tx_only_on_write_r5: assert property (@(posedge clk) disable iff (rst)
    !data_wr |=> !tx_valid);

  p_iid_read_clears_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wr_en && sel == 3'd2 && iid == 8'h02) |=> !pend);
endmodule

bind serial_hostregs sh_checker u_sh_checker (
  .clk      (clk),
  .rst      (rst),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .sel      (addr[2:0]),
  .rdata    (rdata),
  .rx_valid (rx_valid),
  .rx_byte  (rx_byte),
  .brk_in   (brk_in),
  .tx_valid (tx_valid_o),
  .irq      (irq_o),
  .lsr      (lsr_q),
  .rbr      (rbr_q),
  .pend     (pend_q),
  .mcr      (mcr_q),
  .lcr      (lcr_q),
  .iid      (iid_w)
);

// File: tb/test_serial_hostregs.sv
`timescale 1ns/1ps
module test_serial_hostregs;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq_o, tx_valid_o, rx_ready_o, brk_o;
  logic [7:0] tx_byte_o;
  logic       rx_valid = 1'b0, brk_in = 1'b0;
  logic [7:0] rx_byte = '0;
  logic [3:0] modem_in = 4'b1011;
  logic [3:0] mctl_o;
  logic [15:0] divisor_o;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  serial_hostregs i_serial_hostregs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_o(irq_o), .tx_valid_o(tx_valid_o),
    .tx_byte_o(tx_byte_o), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_ready_o(rx_ready_o), .brk_in(brk_in), .modem_in(modem_in),
    .mctl_o(mctl_o), .brk_o(brk_o), .divisor_o(divisor_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic idle(); @(negedge clk); endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); d = rdata; rd_en = 1'b0;
  endtask

  task automatic rx_put(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_byte = b;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic brk_pulse();
    @(negedge clk); brk_in = 1'b1;
    @(negedge clk); brk_in = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [7:0] e8;
    do_reset();

    // R11 reset state
    chk("R11 irq", irq_o, 0);
    chk("R11 rx_ready", rx_ready_o, 1);
    chk("R11 divisor", divisor_o, 0);
    chk("R11 tx_valid", tx_valid_o, 0);
    chk("R11 brk_o", brk_o, 0);
    chk("R11 mctl", mctl_o, 0);
    for (int a = 0; a < 8; a++) begin
      rd(a[2:0], v);
      case (a)
        2: e8 = 8'h01;
        5: e8 = 8'h60;
        6: e8 = 8'hB0;
        default: e8 = 8'h00;
      endcase
      chk($sformatf("R11 offset %0d", a), v, e8);
    end

    // R1 full-byte registers and line-control break
    for (int i = 0; i < 256; i++) begin
      wr(3'd7, i[7:0]); rd(3'd7, v); chk("R1 scratch", v, i[7:0]);
      wr(3'd3, i[7:0]); rd(3'd3, v); chk("R1 lctl", v, i[7:0]);
      chk("R1 brk_o", brk_o, i[6]);
    end

    // R3 masks
    do_reset();
    for (int i = 0; i < 256; i++) begin
      wr(3'd1, i[7:0]); rd(3'd1, v); chk("R3 ien mask", v, i & 8'h0F);
      wr(3'd4, i[7:0]); rd(3'd4, v); chk("R3 mctl mask", v, i & 8'h1F);
      chk("R1 mctl_o", mctl_o, i[3:0]);
    end
    do_reset();
    wr(3'd2, 8'hFF); wr(3'd5, 8'h00); wr(3'd6, 8'h00);
    rd(3'd2, v); chk("R3 offset 2 ignored", v, 8'h01);
    rd(3'd5, v); chk("R3 offset 5 ignored", v, 8'h60);
    rd(3'd6, v); chk("R3 offset 6 ignored", v, 8'hB0);
    chk("R3 irq quiet", irq_o, 0);

    // R2 divisor access
    for (int i = 0; i < 8; i++) begin
      logic [15:0] dv;
      dv = 16'(i * 16'h2345 + 1);
      do_reset();
      rx_put(8'h99);
      wr(3'd3, 8'h80);
      wr(3'd0, dv[7:0]); chk("R2 no tx in divisor mode", tx_valid_o, 0);
      wr(3'd1, dv[15:8]);
      chk("R2 divisor_o", divisor_o, dv);
      rd(3'd0, v); chk("R2 divisor low", v, dv[7:0]);
      rd(3'd1, v); chk("R2 divisor high", v, dv[15:8]);
      rd(3'd5, v); chk("R2 status kept", v, 8'h61);
      wr(3'd3, 8'h00);
      rd(3'd1, v); chk("R2 ien untouched", v, 8'h00);
      rd(3'd0, v); chk("R2 buffer untouched", v, 8'h99);
    end

    // R4 / R6 priority sweep
    for (int en = 0; en < 16; en++) begin
      for (int d = 0; d < 2; d++) begin
        logic [7:0] exp_id;
        do_reset();
        if (d == 1) rx_put(8'(8'h40 + en));
        wr(3'd1, en[7:0]);
        idle();
        exp_id = (d == 1 && en[0]) ? 8'h04 : (en[1] ? 8'h02 : 8'h01);
        chk($sformatf("R4 irq en=%0d d=%0d", en, d), irq_o, exp_id != 8'h01);
        rd(3'd2, v); chk($sformatf("R4 id en=%0d d=%0d", en, d), v, exp_id);
        if (exp_id == 8'h02) begin
          rd(3'd2, v); chk("R6 id read clears pending", v, 8'h01);
          idle(); chk("R6 irq drops", irq_o, 0);
        end
        if (exp_id == 8'h04) begin
          rd(3'd0, v); chk("R7 buffer read", v, 8'(8'h40 + en));
          rd(3'd2, v); chk("R4 next source", v, en[1] ? 8'h02 : 8'h01);
        end
      end
    end

    // R5 transmit
    do_reset();
    wr(3'd1, 8'h02);
    rd(3'd2, v); chk("R6 ien write sets pending", v, 8'h02);
    idle(); chk("R6 irq clear", irq_o, 0);
    for (int i = 0; i < 8; i++) begin
      e8 = 8'(i * 37 + 3);
      wr(3'd0, e8);
      chk("R5 tx strobe", tx_valid_o, 1);
      chk("R5 tx byte", tx_byte_o, e8);
      idle();
      chk("R5 strobe one cycle", tx_valid_o, 0);
      chk("R5 pending irq", irq_o, 1);
      rd(3'd5, v); chk("R5 line status", v, 8'h60);
      rd(3'd2, v); chk("R5 id", v, 8'h02);
    end

    // R7 receive handshake
    do_reset();
    rx_put(8'h11);
    chk("R7 ready low", rx_ready_o, 0);
    rx_put(8'h22);
    rd(3'd5, v); chk("R7 status", v, 8'h61);
    rd(3'd0, v); chk("R7 second byte refused", v, 8'h11);
    rd(3'd5, v); chk("R7 status cleared", v, 8'h60);
    chk("R7 ready high", rx_ready_o, 1);

    // R8 break
    do_reset();
    rx_put(8'h77);
    brk_pulse();
    rd(3'd5, v); chk("R8 status", v, 8'h71);
    rd(3'd0, v); chk("R8 buffer zero", v, 8'h00);
    rd(3'd5, v); chk("R8 cleared by read", v, 8'h60);

    // R9 loopback transmit
    do_reset();
    wr(3'd4, 8'h10);
    wr(3'd0, 8'h5A);
    chk("R9 no tx strobe", tx_valid_o, 0);
    rd(3'd5, v); chk("R9 status", v, 8'h61);
    rd(3'd0, v); chk("R9 looped byte", v, 8'h5A);

    // R10 modem status
    for (int m = 0; m < 16; m++) begin
      wr(3'd4, 8'(8'h10 | m));
      rd(3'd6, v);
      chk("R10 loop view", v, {m[3], m[2], m[0], m[1], 4'b0});
    end
    wr(3'd4, 8'h00);
    for (int m = 0; m < 16; m++) begin
      modem_in = m[3:0];
      idle();
      rd(3'd6, v);
      chk("R10 external view", v, {m[3:0], 4'b0});
    end

    // R12 read data holds
    wr(3'd7, 8'hC3);
    rd(3'd7, v);
    wr(3'd7, 8'h00);
    idle(); idle();
    chk("R12 rdata holds", rdata, 8'hC3);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule